// File: doc/BRIEF.md
# Repeater Embedded-Operations Message Address Processor

This block sits in a digital subscriber line repeater and handles the embedded operations channel in both directions. The framer delivers the channel as serial overhead bits. The block turns them into 12-bit messages: one stream arrives from the line and goes toward the system, the other arrives from the system and goes toward the line. Each finished message is delivered as a parallel word with a one-cycle valid strobe, held in a per-direction output register that a reader clears.

Repeaters are chained, so each hop must rewrite the message address. In auto mode, a message that arrives from the line has its address decremented by one before it goes to the system side. A message that arrives from the system side has its address incremented by one before it goes toward the line. Each direction has an address window. A message whose address falls outside that window is not forwarded; it is raised on a separate local-message output instead. In non-auto mode the block does not interpret messages and forwards every one unchanged. The rewrite never depends on whether the message carries a command or raw data.

Top module: `eoc_rptr_addr_proc`

## Requirements
- R1: A message is 12 bits, shifted in most significant bit first: address in bits [11:9], data/message indicator in bit [8], information in bits [7:0]. A message is committed on the clock edge that accepts its 12th bit, and its result appears at the outputs on the following cycle.
- R2: With `auto_mode` low, every committed message is forwarded with all 12 bits unchanged, and no local strobe is raised.
- R3: With `auto_mode` high, a message from the line side with address 2 to 6 is forwarded on `to_sys_msg` with its address reduced by one.
- R4: With `auto_mode` high, a message from the system side with address 1 to 5 is forwarded on `to_ln_msg` with its address increased by one.
- R5: With `auto_mode` high, a message whose address is outside its direction's window is not forwarded. It raises that side's local strobe for one cycle, and the unchanged word appears on that side's local output.
- R6: Bits [8:0] of a forwarded message equal the received bits, whether the indicator bit [8] is 0 or 1.
- R7: A message starts only at a valid bit flagged as first. Valid bits that arrive while no message is in progress are ignored. A first-flagged bit in the middle of a message discards the partial message and starts a new one.
- R8: A forwarded message pulses its valid output for exactly one cycle and sets its full flag. The full flag stays set until the read input for that direction is asserted.
- R9: If a message is forwarded while the full flag is set and no read is asserted in that cycle, the overrun flag is set and the new word replaces the old one. A read clears both flags.
- R10: After reset, all valid, full, overrun and local outputs are 0 and all message outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 1: repeater address rewrite; 0: pass-through |
| ln_bit_vld | input | 1 | Serial bit from line side is valid |
| ln_bit_first | input | 1 | This line-side bit starts a message |
| ln_bit | input | 1 | Line-side serial bit |
| sys_bit_vld | input | 1 | Serial bit from system side is valid |
| sys_bit_first | input | 1 | This system-side bit starts a message |
| sys_bit | input | 1 | System-side serial bit |
| to_sys_rd | input | 1 | Reader has taken the system-bound word |
| to_ln_rd | input | 1 | Reader has taken the line-bound word |
| to_sys_msg | output | 12 | Message forwarded to the system side |
| to_sys_vld | output | 1 | One-cycle strobe: new system-bound word |
| to_sys_full | output | 1 | System-bound word not yet read |
| to_sys_ovr | output | 1 | System-bound word overwritten before read |
| to_ln_msg | output | 12 | Message forwarded toward the line |
| to_ln_vld | output | 1 | One-cycle strobe: new line-bound word |
| to_ln_full | output | 1 | Line-bound word not yet read |
| to_ln_ovr | output | 1 | Line-bound word overwritten before read |
| ln_loc_vld | output | 1 | Line-side message kept local (strobe) |
| ln_loc_msg | output | 12 | Last line-side message kept local |
| sys_loc_vld | output | 1 | System-side message kept local (strobe) |
| sys_loc_msg | output | 12 | Last system-side message kept local |

## Verification
A wrong bit count or a bad start condition in an assembler shows up one cycle after the twelfth bit. The symptom is a strobe that is missing, early or extra, or a word that is shifted by whole bit positions. A wrong window bound or step direction shows up as a wrong address field, or as a local strobe where a forward was due, on the cycle after commit. A bad full or overrun state stays hidden until the next forward or read on that side. Each of these is checked at exactly that point.

// File: rtl/eoc_rpt_pkg.sv
package eoc_rpt_pkg;

  typedef enum logic {
    DIR_L2S = 1'b0,
    DIR_S2L = 1'b1
  } eoc_dir_e;

  function automatic logic addr_in_window(input int unsigned addr,
                                          input int unsigned lo,
                                          input int unsigned hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

  function automatic int unsigned step_addr(input int unsigned addr,
                                            input eoc_dir_e dir);
    return (dir == DIR_L2S) ? addr - 1 : addr + 1;
  endfunction

endpackage

// File: rtl/eoc_msg_shifter.sv
module eoc_msg_shifter #(
  parameter int unsigned MSG_W = 12,
  localparam int unsigned CNT_W = $clog2(MSG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_first,
  input  logic             bit_in,
  output logic             msg_done,
  output logic [MSG_W-1:0] msg_word
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [MSG_W-2:0] sreg;
  logic             accept;

  assign accept   = bit_vld && (bit_first || (cnt != '0));
  assign cnt_nxt  = bit_first ? CNT_W'(1) : cnt + CNT_W'(1);
  assign msg_word = {sreg, bit_in};
  assign msg_done = accept && (cnt_nxt == CNT_W'(MSG_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (accept) begin
      sreg <= msg_word[MSG_W-2:0];
      cnt  <= msg_done ? '0 : cnt_nxt;
    end
  end

endmodule

// File: rtl/eoc_addr_rewrite.sv
module eoc_addr_rewrite
  import eoc_rpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned INFO_W = 8,
  parameter eoc_dir_e    DIR    = DIR_L2S,
  parameter int unsigned WIN_LO = 2,
  parameter int unsigned WIN_HI = 6,
  localparam int unsigned MSG_W = ADDR_W + 1 + INFO_W
) (
  input  logic             auto_mode,
  input  logic [MSG_W-1:0] raw_word,
  output logic [MSG_W-1:0] fwd_word,
  output logic             is_local
);

  logic [31:0] addr_u;
  logic        in_win;

  assign addr_u = 32'(raw_word[MSG_W-1 -: ADDR_W]);
  assign in_win = addr_in_window(addr_u, WIN_LO, WIN_HI);

  always_comb begin
    fwd_word = raw_word;
    is_local = 1'b0;
    if (auto_mode) begin
      if (in_win) begin
        fwd_word[MSG_W-1 -: ADDR_W] = ADDR_W'(step_addr(addr_u, DIR));
      end else begin
        is_local = 1'b1;
      end
    end
  end

endmodule

// File: rtl/eoc_fwd_hold.sv
module eoc_fwd_hold #(
  parameter int unsigned MSG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MSG_W-1:0] load_word,
  input  logic             rd,
  output logic [MSG_W-1:0] out_word,
  output logic             out_vld,
  output logic             out_full,
  output logic             out_ovr
);

  logic ovr_set;

  assign ovr_set = load && out_full && !rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word <= '0;
      out_vld  <= 1'b0;
      out_full <= 1'b0;
      out_ovr  <= 1'b0;
    end else begin
      out_vld  <= load;
      out_full <= load || (out_full && !rd);
      out_ovr  <= ovr_set || (out_ovr && !rd);
      if (load) begin
        out_word <= load_word;
      end
    end
  end

endmodule

// File: rtl/eoc_dir_channel.sv
module eoc_dir_channel
  import eoc_rpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned INFO_W = 8,
  parameter eoc_dir_e    DIR    = DIR_L2S,
  parameter int unsigned WIN_LO = 2,
  parameter int unsigned WIN_HI = 6,
  localparam int unsigned MSG_W = ADDR_W + 1 + INFO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode,
  input  logic             bit_vld,
  input  logic             bit_first,
  input  logic             bit_in,
  input  logic             rd,
  output logic [MSG_W-1:0] fwd_word,
  output logic             fwd_vld,
  output logic             fwd_full,
  output logic             fwd_ovr,
  output logic [MSG_W-1:0] loc_word,
  output logic             loc_vld,
  output logic             commit,
  output logic             commit_local,
  output logic [MSG_W-1:0] raw_word
);

  logic [MSG_W-1:0] rew_word;
  logic             fwd_load;
  logic             loc_load;

  eoc_msg_shifter #(.MSG_W(MSG_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_first (bit_first),
    .bit_in    (bit_in),
    .msg_done  (commit),
    .msg_word  (raw_word)
  );

  eoc_addr_rewrite #(
    .ADDR_W (ADDR_W),
    .INFO_W (INFO_W),
    .DIR    (DIR),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) u_rew (
    .auto_mode (auto_mode),
    .raw_word  (raw_word),
    .fwd_word  (rew_word),
    .is_local  (commit_local)
  );

  assign fwd_load = commit && !commit_local;
  assign loc_load = commit && commit_local;

  eoc_fwd_hold #(.MSG_W(MSG_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fwd_load),
    .load_word (rew_word),
    .rd        (rd),
    .out_word  (fwd_word),
    .out_vld   (fwd_vld),
    .out_full  (fwd_full),
    .out_ovr   (fwd_ovr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_word <= '0;
      loc_vld  <= 1'b0;
    end else begin
      loc_vld <= loc_load;
      if (loc_load) begin
        loc_word <= raw_word;
      end
    end
  end

endmodule

// File: rtl/eoc_rptr_addr_proc.sv
module eoc_rptr_addr_proc
  import eoc_rpt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned INFO_W    = 8,
  parameter int unsigned L2S_WIN_LO = 2,
  parameter int unsigned L2S_WIN_HI = 6,
  parameter int unsigned S2L_WIN_LO = 1,
  parameter int unsigned S2L_WIN_HI = 5,
  localparam int unsigned MSG_W    = ADDR_W + 1 + INFO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode,
  input  logic             ln_bit_vld,
  input  logic             ln_bit_first,
  input  logic             ln_bit,
  input  logic             sys_bit_vld,
  input  logic             sys_bit_first,
  input  logic             sys_bit,
  input  logic             to_sys_rd,
  input  logic             to_ln_rd,
  output logic [MSG_W-1:0] to_sys_msg,
  output logic             to_sys_vld,
  output logic             to_sys_full,
  output logic             to_sys_ovr,
  output logic [MSG_W-1:0] to_ln_msg,
  output logic             to_ln_vld,
  output logic             to_ln_full,
  output logic             to_ln_ovr,
  output logic             ln_loc_vld,
  output logic [MSG_W-1:0] ln_loc_msg,
  output logic             sys_loc_vld,
  output logic [MSG_W-1:0] sys_loc_msg
);

  localparam int unsigned NDIR = 2;

  logic [NDIR-1:0]  in_vld, in_first, in_bit, rd_a;
  logic [NDIR-1:0]  fwd_vld_a, full_a, ovr_a, loc_vld_a;
  logic [NDIR-1:0]  commit_w, local_w;
  logic [MSG_W-1:0] fwd_word_a [NDIR];
  logic [MSG_W-1:0] loc_word_a [NDIR];
  logic [MSG_W-1:0] raw_w      [NDIR];

  assign in_vld   = {sys_bit_vld,   ln_bit_vld};
  assign in_first = {sys_bit_first, ln_bit_first};
  assign in_bit   = {sys_bit,       ln_bit};
  assign rd_a     = {to_ln_rd,      to_sys_rd};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam eoc_dir_e    DIR_P = (d == 0) ? DIR_L2S : DIR_S2L;
    localparam int unsigned LO_P  = (d == 0) ? L2S_WIN_LO : S2L_WIN_LO;
    localparam int unsigned HI_P  = (d == 0) ? L2S_WIN_HI : S2L_WIN_HI;

    eoc_dir_channel #(
      .ADDR_W (ADDR_W),
      .INFO_W (INFO_W),
      .DIR    (DIR_P),
      .WIN_LO (LO_P),
      .WIN_HI (HI_P)
    ) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .auto_mode    (auto_mode),
      .bit_vld      (in_vld[d]),
      .bit_first    (in_first[d]),
      .bit_in       (in_bit[d]),
      .rd           (rd_a[d]),
      .fwd_word     (fwd_word_a[d]),
      .fwd_vld      (fwd_vld_a[d]),
      .fwd_full     (full_a[d]),
      .fwd_ovr      (ovr_a[d]),
      .loc_word     (loc_word_a[d]),
      .loc_vld      (loc_vld_a[d]),
      .commit       (commit_w[d]),
      .commit_local (local_w[d]),
      .raw_word     (raw_w[d])
    );
  end

  assign to_sys_msg  = fwd_word_a[0];
  assign to_sys_vld  = fwd_vld_a[0];
  assign to_sys_full = full_a[0];
  assign to_sys_ovr  = ovr_a[0];
  assign ln_loc_vld  = loc_vld_a[0];
  assign ln_loc_msg  = loc_word_a[0];

  assign to_ln_msg   = fwd_word_a[1];
  assign to_ln_vld   = fwd_vld_a[1];
  assign to_ln_full  = full_a[1];
  assign to_ln_ovr   = ovr_a[1];
  assign sys_loc_vld = loc_vld_a[1];
  assign sys_loc_msg = loc_word_a[1];

endmodule

// File: rtl/eoc_rptr_checker.sv
module eoc_rptr_checker #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned INFO_W = 8,
  localparam int unsigned MSG_W = ADDR_W + 1 + INFO_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_mode,
  input logic [1:0]       commit,
  input logic [1:0]       is_loc,
  input logic [MSG_W-1:0] raw0,
  input logic [MSG_W-1:0] raw1,
  input logic [MSG_W-1:0] to_sys_msg,
  input logic             to_sys_vld,
  input logic             to_sys_full,
  input logic             to_sys_ovr,
  input logic [MSG_W-1:0] to_ln_msg,
  input logic             to_ln_vld,
  input logic             to_ln_full,
  input logic             to_ln_ovr,
  input logic             to_ln_rd,
  input logic             ln_loc_vld,
  input logic             sys_loc_vld
);

  // R2
  nonauto_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[0] && !auto_mode |=> to_sys_vld && (to_sys_msg == $past(raw0)));

  // R3
  l2s_dec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[0] && auto_mode && !is_loc[0] |=>
      to_sys_msg[MSG_W-1 -: ADDR_W] == $past(raw0[MSG_W-1 -: ADDR_W]) - ADDR_W'(1));

  // R4
  s2l_inc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[1] && auto_mode && !is_loc[1] |=>
      to_ln_msg[MSG_W-1 -: ADDR_W] == $past(raw1[MSG_W-1 -: ADDR_W]) + ADDR_W'(1));

  // R5
  l2s_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[0] && is_loc[0] |=> ln_loc_vld && !to_sys_vld);

  // R5
  s2l_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[1] && is_loc[1] |=> sys_loc_vld && !to_ln_vld);

  // R6
  s2l_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[1] && !is_loc[1] |=> to_ln_msg[MSG_W-ADDR_W-1:0] == $past(raw1[MSG_W-ADDR_W-1:0]));

  // R8
  s2l_fwd_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[1] && !is_loc[1] |=> to_ln_vld && to_ln_full);

  // R8
  s2l_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_ln_rd && !commit[1] |=> !to_ln_full && !to_ln_ovr);

  // R9
  l2s_ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_sys_ovr |-> to_sys_full);

endmodule

bind eoc_rptr_addr_proc eoc_rptr_checker #(
  .ADDR_W (ADDR_W),
  .INFO_W (INFO_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .auto_mode   (auto_mode),
  .commit      (commit_w),
  .is_loc      (local_w),
  .raw0        (raw_w[0]),
  .raw1        (raw_w[1]),
  .to_sys_msg  (to_sys_msg),
  .to_sys_vld  (to_sys_vld),
  .to_sys_full (to_sys_full),
  .to_sys_ovr  (to_sys_ovr),
  .to_ln_msg   (to_ln_msg),
  .to_ln_vld   (to_ln_vld),
  .to_ln_full  (to_ln_full),
  .to_ln_ovr   (to_ln_ovr),
  .to_ln_rd    (to_ln_rd),
  .ln_loc_vld  (ln_loc_vld),
  .sys_loc_vld (sys_loc_vld)
);

// File: tb/sim_eoc_rptr_addr_proc.sv
`timescale 1ns/1ps
module sim_eoc_rptr_addr_proc;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mode = 1'b1;
  logic ln_bit_vld = 1'b0, ln_bit_first = 1'b0, ln_bit = 1'b0;
  logic sys_bit_vld = 1'b0, sys_bit_first = 1'b0, sys_bit = 1'b0;
  logic to_sys_rd = 1'b0, to_ln_rd = 1'b0;
  logic [11:0] to_sys_msg, to_ln_msg, ln_loc_msg, sys_loc_msg;
  logic to_sys_vld, to_sys_full, to_sys_ovr;
  logic to_ln_vld, to_ln_full, to_ln_ovr;
  logic ln_loc_vld, sys_loc_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [11:0] q_sys_w[$], q_ln_w[$], q_ll_w[$], q_sl_w[$];
  string       q_sys_t[$], q_ln_t[$], q_ll_t[$], q_sl_t[$];

  always #2 clk = ~clk;

  eoc_rptr_addr_proc u0 (
    .clk (clk), .rst_n (rst_n), .auto_mode (auto_mode),
    .ln_bit_vld (ln_bit_vld), .ln_bit_first (ln_bit_first), .ln_bit (ln_bit),
    .sys_bit_vld (sys_bit_vld), .sys_bit_first (sys_bit_first), .sys_bit (sys_bit),
    .to_sys_rd (to_sys_rd), .to_ln_rd (to_ln_rd),
    .to_sys_msg (to_sys_msg), .to_sys_vld (to_sys_vld),
    .to_sys_full (to_sys_full), .to_sys_ovr (to_sys_ovr),
    .to_ln_msg (to_ln_msg), .to_ln_vld (to_ln_vld),
    .to_ln_full (to_ln_full), .to_ln_ovr (to_ln_ovr),
    .ln_loc_vld (ln_loc_vld), .ln_loc_msg (ln_loc_msg),
    .sys_loc_vld (sys_loc_vld), .sys_loc_msg (sys_loc_msg)
  );

  task automatic check(input bit ok, input string req,
                       input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard model: address handling per direction and mode.
  task automatic expect_msg(input bit s2l, input logic [11:0] w, input string tag);
    logic [2:0]  a = w[11:9];
    logic [11:0] o = w;
    bit          loc = 0;
    if (auto_mode) begin
      if (!s2l) begin
        case (a)
          3'd2, 3'd3, 3'd4, 3'd5, 3'd6: o[11:9] = a - 3'd1;
          default: loc = 1;
        endcase
      end else begin
        case (a)
          3'd1, 3'd2, 3'd3, 3'd4, 3'd5: o[11:9] = a + 3'd1;
          default: loc = 1;
        endcase
      end
    end
    if (!s2l && !loc) begin q_sys_w.push_back(o); q_sys_t.push_back(tag); end
    if (!s2l &&  loc) begin q_ll_w.push_back(w);  q_ll_t.push_back(tag);  end
    if ( s2l && !loc) begin q_ln_w.push_back(o);  q_ln_t.push_back(tag);  end
    if ( s2l &&  loc) begin q_sl_w.push_back(w);  q_sl_t.push_back(tag);  end
  endtask

  task automatic drive_bits(input bit s2l, input logic [11:0] w,
                            input int nbits, input bit with_first);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (s2l) begin
        sys_bit_vld = 1'b1; sys_bit = w[11-i]; sys_bit_first = with_first && (i == 0);
      end else begin
        ln_bit_vld = 1'b1; ln_bit = w[11-i]; ln_bit_first = with_first && (i == 0);
      end
    end
    @(negedge clk);
    sys_bit_vld = 1'b0; sys_bit_first = 1'b0;
    ln_bit_vld = 1'b0; ln_bit_first = 1'b0;
  endtask

  task automatic pulse_rd(input bit s2l);
    @(negedge clk);
    if (s2l) to_ln_rd = 1'b1; else to_sys_rd = 1'b1;
    @(negedge clk);
    to_ln_rd = 1'b0; to_sys_rd = 1'b0;
  endtask

  task automatic send_msg(input bit s2l, input logic [11:0] w,
                          input string tag, input bit do_rd);
    expect_msg(s2l, w, tag);
    drive_bits(s2l, w, 12, 1'b1);
    if (do_rd) pulse_rd(s2l);
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (to_sys_vld) begin
        if (q_sys_w.size() == 0) check(0, "R8 unexpected to_sys word", to_sys_msg, 12'h000);
        else check(to_sys_msg == q_sys_w[0], q_sys_t[0], to_sys_msg, q_sys_w[0]);
        if (q_sys_w.size() != 0) begin void'(q_sys_w.pop_front()); void'(q_sys_t.pop_front()); end
      end
      if (to_ln_vld) begin
        if (q_ln_w.size() == 0) check(0, "R8 unexpected to_ln word", to_ln_msg, 12'h000);
        else check(to_ln_msg == q_ln_w[0], q_ln_t[0], to_ln_msg, q_ln_w[0]);
        if (q_ln_w.size() != 0) begin void'(q_ln_w.pop_front()); void'(q_ln_t.pop_front()); end
      end
      if (ln_loc_vld) begin
        if (q_ll_w.size() == 0) check(0, "R5 unexpected line local", ln_loc_msg, 12'h000);
        else check(ln_loc_msg == q_ll_w[0], q_ll_t[0], ln_loc_msg, q_ll_w[0]);
        if (q_ll_w.size() != 0) begin void'(q_ll_w.pop_front()); void'(q_ll_t.pop_front()); end
      end
      if (sys_loc_vld) begin
        if (q_sl_w.size() == 0) check(0, "R5 unexpected system local", sys_loc_msg, 12'h000);
        else check(sys_loc_msg == q_sl_w[0], q_sl_t[0], sys_loc_msg, q_sl_w[0]);
        if (q_sl_w.size() != 0) begin void'(q_sl_w.pop_front()); void'(q_sl_t.pop_front()); end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check({to_sys_vld, to_sys_full, to_sys_ovr, to_ln_vld, to_ln_full, to_ln_ovr,
           ln_loc_vld, sys_loc_vld} == 8'h00, "R10 flags in reset",
          {4'h0, to_sys_vld, to_sys_full, to_sys_ovr, to_ln_vld, to_ln_full, to_ln_ovr,
           ln_loc_vld, sys_loc_vld}, 12'h000);
    check((to_sys_msg | to_ln_msg | ln_loc_msg | sys_loc_msg) == 12'h000,
          "R10 words in reset", to_sys_msg | to_ln_msg, 12'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R6: line side, window edges, both indicator values
    auto_mode = 1'b1;
    send_msg(0, {3'd2, 1'b1, 8'hA5}, "R3 R1 addr 2 to 1", 1);
    send_msg(0, {3'd6, 1'b0, 8'h3C}, "R3 R6 addr 6 to 5 raw data", 1);
    send_msg(0, {3'd4, 1'b1, 8'h81}, "R3 R6 addr 4 to 3", 1);
    // R5 line side outside window
    send_msg(0, {3'd1, 1'b1, 8'h11}, "R5 line addr 1 local", 1);
    send_msg(0, {3'd7, 1'b0, 8'hFE}, "R5 line addr 7 local", 1);
    send_msg(0, {3'd0, 1'b1, 8'h00}, "R5 line addr 0 local", 1);

    // R4 R6: system side
    send_msg(1, {3'd1, 1'b1, 8'h5A}, "R4 addr 1 to 2", 1);
    send_msg(1, {3'd5, 1'b0, 8'hC3}, "R4 R6 addr 5 to 6 raw data", 1);
    // R5 system side outside window
    send_msg(1, {3'd0, 1'b1, 8'h77}, "R5 sys addr 0 local", 1);
    send_msg(1, {3'd6, 1'b0, 8'h12}, "R5 sys addr 6 local", 1);
    send_msg(1, {3'd7, 1'b1, 8'h9D}, "R5 sys addr 7 local", 1);

    // R2 non-auto pass-through
    auto_mode = 1'b0;
    send_msg(0, {3'd0, 1'b1, 8'h42}, "R2 line addr 0 unchanged", 1);
    send_msg(0, {3'd7, 1'b0, 8'hBD}, "R2 line addr 7 unchanged", 1);
    send_msg(1, {3'd7, 1'b1, 8'h24}, "R2 sys addr 7 unchanged", 1);
    send_msg(1, {3'd3, 1'b0, 8'hE7}, "R2 sys addr 3 unchanged", 1);
    auto_mode = 1'b1;

    // R7 stray bits while idle are ignored; scoreboard flags any extra word
    drive_bits(0, 12'hFFF, 12, 1'b0);
    check(!to_sys_vld && !ln_loc_vld, "R7 no output from unflagged bits",
          {10'h0, to_sys_vld, ln_loc_vld}, 12'h000);
    send_msg(0, {3'd3, 1'b1, 8'h69}, "R7 message after stray bits", 1);
    // R7 restart: partial message discarded
    drive_bits(1, 12'hFFF, 7, 1'b1);
    send_msg(1, {3'd2, 1'b0, 8'h0F}, "R7 message after restart", 1);

    // R8 full set, vld one cycle
    send_msg(1, {3'd3, 1'b1, 8'hAA}, "R8 first unread", 0);
    check(to_ln_full == 1'b1, "R8 full after forward", {11'h0, to_ln_full}, 12'h001);
    @(negedge clk);
    check(to_ln_vld == 1'b0, "R8 vld lasts one cycle", {11'h0, to_ln_vld}, 12'h000);
    check(to_ln_full == 1'b1, "R8 full held until read", {11'h0, to_ln_full}, 12'h001);
    // R9 overrun
    send_msg(1, {3'd4, 1'b0, 8'h55}, "R9 overwriting word", 0);
    check(to_ln_ovr == 1'b1, "R9 overrun set", {11'h0, to_ln_ovr}, 12'h001);
    check(to_ln_msg == {3'd5, 1'b0, 8'h55}, "R9 new word replaces old", to_ln_msg,
          {3'd5, 1'b0, 8'h55});
    pulse_rd(1);
    check({to_ln_full, to_ln_ovr} == 2'b00, "R9 read clears flags",
          {10'h0, to_ln_full, to_ln_ovr}, 12'h000);
    // R9 line side overrun
    send_msg(0, {3'd5, 1'b1, 8'h01}, "R9 line first", 0);
    send_msg(0, {3'd6, 1'b1, 8'h02}, "R9 line second", 0);
    check({to_sys_full, to_sys_ovr} == 2'b11, "R9 line overrun",
          {10'h0, to_sys_full, to_sys_ovr}, 12'h003);
    pulse_rd(0);
    check({to_sys_full, to_sys_ovr} == 2'b00, "R8 line read clears",
          {10'h0, to_sys_full, to_sys_ovr}, 12'h000);

    repeat (4) @(negedge clk);
    check((q_sys_w.size() + q_ln_w.size() + q_ll_w.size() + q_sl_w.size()) == 0,
          "R8 all expected items delivered",
          12'(q_sys_w.size() + q_ln_w.size() + q_ll_w.size() + q_sl_w.size()), 12'h000);
    finish_run();
  end

endmodule